// File: doc/BRIEF.md
# Four-Channel Edge Capture with First-Edge Polarity Status

This block timestamps transitions on four external input pins. Each pin passes through a two-stage synchroniser and then an edge detector. When a channel sees an edge of a kind its mode allows, the channel copies the current value of an externally supplied free-running timer into its own capture latch. The timer counter is not part of the block. It arrives as an input bus.

Each channel also keeps one status bit that records the direction of the first capturing edge since software last read that channel's latch. Later captures in the same interval keep updating the latch, but they leave the status bit alone. A read re-arms the tracking, so software can tell which edge opened each measurement window even when several captures have overwritten the timestamp. Reads are synchronous: a read strobe and a channel index return the selected latch on the next clock edge.

Top module: `edge_capture_unit`

## Requirements
- R1: A level change on `cap_in[i]` is resynchronised through two flip-flops. When it forms an enabled edge, the latch of channel i loads the `timer_cnt` value present at the third rising clock edge after the change.
- R2: Bits `edge_sel[2i+1:2i]` choose the mode of channel i. 00 captures nothing, 01 captures rising edges only, 10 captures falling edges only, and 11 captures both.
- R3: When `rd_en` is high at a clock edge, `rd_data` shows the latch of channel `rd_sel` from that edge onward. It holds its value when no read is made.
- R4: For the first capture of an interval, `pol_status[i]` becomes 1 if a rising edge caused it and 0 if a falling edge caused it.
- R5: After the first capture of an interval, later captures on the same channel still reload its latch but leave `pol_status[i]` unchanged.
- R6: A read of channel i starts a new interval for channel i only. The next capture on that channel sets its status bit again.
- R7: A capture that falls in the same cycle as a read of its channel counts as the first capture of the new interval. That read returns the latch value from before the capture.
- R8: After reset, all status bits, all latches and `rd_data` are zero, and every channel is armed for a first capture.
- R9: The status bits are read-only. Reads, ignored edges and disabled channels never alter them. Only a capture changes a status bit.
- R10: Channels are independent: activity on one channel changes neither the latch nor the status bit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_cnt | input | TW | Free-running timer value to be captured |
| cap_in | input | NUM_CH | Asynchronous capture pins, one per channel |
| edge_sel | input | 2*NUM_CH | Per-channel edge mode, two bits per channel |
| rd_en | input | 1 | Read strobe for one capture latch |
| rd_sel | input | SEL_W | Channel index for the read |
| rd_data | output | TW | Registered latch contents of the last read |
| pol_status | output | NUM_CH | First-edge polarity status, one bit per channel |

## Verification
The bench drives several edges of opposite direction into one interval. A design that tracked the most recent edge instead of the first would flip the status bit on the second capture. It also places a capture exactly in the cycle of a read. A design that ordered the re-arm after the capture would leave the status stale, and a design that forwarded the new timestamp would return the wrong read value. Disabled channels and edges of the wrong direction are toggled while the bench watches the status and the read data, which would expose a detector that ignores its mode. Exact read values pin down the three-cycle capture latency.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/edge_sync_detect.sv
module edge_sync_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/capture_channel.sv
module capture_channel
  import icap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  edge_mode_e    mode,
  input  logic          rise,
  input  logic          fall,
  input  logic [TW-1:0] timer,
  input  logic          rearm,
  output logic [TW-1:0] latch_q,
  output logic          pol_q,
  output logic          evt
);
  logic armed_q;

  // mode bit 0 enables rising edges, bit 1 enables falling edges
  assign evt = (rise & mode[0]) | (fall & mode[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      pol_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (evt) begin
      latch_q <= timer;
      if (armed_q || rearm) pol_q <= rise;
      armed_q <= 1'b0;
    end else if (rearm) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import icap_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TW-1:0]       timer_cnt,
  input  logic [NUM_CH-1:0]   cap_in,
  input  logic [2*NUM_CH-1:0] edge_sel,
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [TW-1:0]       rd_data,
  output logic [NUM_CH-1:0]   pol_status
);
  logic [NUM_CH-1:0]         ch_rise;
  logic [NUM_CH-1:0]         ch_fall;
  logic [NUM_CH-1:0]         cap_evt;
  logic [NUM_CH-1:0]         rearm;
  logic [NUM_CH-1:0][TW-1:0] latch_arr;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign rearm[i] = rd_en && (rd_sel == SEL_W'(i));

    edge_sync_detect #(.STAGES(SYNC_STAGES)) u_det (
      .clk  (clk),
      .rst  (rst),
      .pin  (cap_in[i]),
      .rise (ch_rise[i]),
      .fall (ch_fall[i])
    );

    capture_channel #(.TW(TW)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .mode    (edge_mode_e'(edge_sel[2*i +: 2])),
      .rise    (ch_rise[i]),
      .fall    (ch_fall[i]),
      .timer   (timer_cnt),
      .rearm   (rearm[i]),
      .latch_q (latch_arr[i]),
      .pol_q   (pol_status[i]),
      .evt     (cap_evt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= latch_arr[rd_sel];
  end
endmodule

// File: rtl/icap_checker.sv
module icap_checker #(
  parameter int NUM_CH = 4,
  parameter int TW     = 16,
  parameter int SEL_W  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [TW-1:0]             timer_cnt,
  input logic [2*NUM_CH-1:0]       edge_sel,
  input logic                      rd_en,
  input logic [SEL_W-1:0]          rd_sel,
  input logic [TW-1:0]             rd_data,
  input logic [NUM_CH-1:0]         pol_status,
  input logic [NUM_CH-1:0]         evt,
  input logic [NUM_CH-1:0]         rise,
  input logic [NUM_CH-1:0][TW-1:0] latch
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pol_status == '0 && rd_data == '0)); // R8

  AST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(latch[rd_sel])); // R3

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> latch[i] == $past(timer_cnt)); // R1

    AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (edge_sel[2*i +: 2] == 2'b00) |-> !evt[i]); // R2

    AST_POL_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      !evt[i] |=> $stable(pol_status[i])); // R9

    AST_SAME_CYCLE_FIRST: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && rd_en && rd_sel == SEL_W'(i)) |=> pol_status[i] == $past(rise[i])); // R7
  end
endmodule

bind edge_capture_unit icap_checker #(.NUM_CH(NUM_CH), .TW(TW), .SEL_W(SEL_W)) u_icap_chk (
  .clk        (clk),
  .rst        (rst),
  .timer_cnt  (timer_cnt),
  .edge_sel   (edge_sel),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .pol_status (pol_status),
  .evt        (cap_evt),
  .rise       (ch_rise),
  .latch      (latch_arr)
);

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timer_cnt = '0;
  logic [3:0]  cap_in = '0;
  logic [7:0]  edge_sel = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [3:0]  pol_status;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  edge_capture_unit uut (
    .clk(clk), .rst(rst), .timer_cnt(timer_cnt), .cap_in(cap_in),
    .edge_sel(edge_sel), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .pol_status(pol_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    @(negedge clk);
    edge_sel[2*ch +: 2] = m;
  endtask

  // change a pin; return at the negedge after the capture edge
  task automatic drive_pin(input int ch, input logic lvl, input logic [15:0] t);
    @(negedge clk);
    timer_cnt = t;
    cap_in[ch] = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_ch(input int ch, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_sel = 2'(ch);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic test_reset();
    logic [15:0] d;
    check(pol_status == 4'b0, "R8 status after reset", pol_status, 0);
    check(rd_data == 16'h0, "R8 rd_data after reset", rd_data, 0);
    for (int c = 0; c < 4; c++) begin
      read_ch(c, d);
      check(d == 16'h0, "R8 latch after reset", d, 0);
    end
  endtask

  task automatic test_rising_first();
    logic [15:0] d;
    set_mode(0, 2'b01);
    drive_pin(0, 1'b1, 16'h1234);
    check(pol_status[0] == 1'b1, "R4 rising first sets status", pol_status[0], 1);
    check(pol_status[3:1] == 3'b0, "R10 other channels untouched", pol_status[3:1], 0);
    read_ch(0, d);
    check(d == 16'h1234, "R1 captured timer value", d, 16'h1234);
    drive_pin(0, 1'b0, 16'h7777);
    read_ch(0, d);
    check(d == 16'h1234, "R2 falling ignored in rising mode", d, 16'h1234);
    check(pol_status[0] == 1'b1, "R9 ignored edge keeps status", pol_status[0], 1);
  endtask

  task automatic test_falling_mode();
    logic [15:0] d;
    set_mode(1, 2'b11);
    drive_pin(1, 1'b1, 16'h0101);
    check(pol_status[1] == 1'b1, "R4 rising sets status ch1", pol_status[1], 1);
    read_ch(1, d);
    set_mode(1, 2'b10);
    drive_pin(1, 1'b0, 16'h00AB);
    check(pol_status[1] == 1'b0, "R4 falling first clears status", pol_status[1], 0);
    read_ch(1, d);
    check(d == 16'h00AB, "R2 falling captured in falling mode", d, 16'h00AB);
    drive_pin(1, 1'b1, 16'h5555);
    read_ch(1, d);
    check(d == 16'h00AB, "R2 rising ignored in falling mode", d, 16'h00AB);
  endtask

  task automatic test_first_only();
    logic [15:0] d;
    set_mode(2, 2'b11);
    drive_pin(2, 1'b1, 16'hA000);
    check(pol_status[2] == 1'b1, "R4 first rising ch2", pol_status[2], 1);
    drive_pin(2, 1'b0, 16'hB000);
    check(pol_status[2] == 1'b1, "R5 second capture keeps status", pol_status[2], 1);
    read_ch(2, d);
    check(d == 16'hB000, "R5 latch follows later capture", d, 16'hB000);
    check(pol_status[2] == 1'b1, "R9 read leaves status", pol_status[2], 1);
    drive_pin(2, 1'b1, 16'hC000);
    drive_pin(2, 1'b0, 16'hC001);
    check(pol_status[2] == 1'b1, "R6 rising after read sets status", pol_status[2], 1);
    read_ch(2, d);
    drive_pin(2, 1'b1, 16'hC002);
    read_ch(2, d);
    drive_pin(2, 1'b0, 16'hC003);
    check(pol_status[2] == 1'b0, "R6 falling after read clears status", pol_status[2], 0);
  endtask

  task automatic test_disabled();
    logic [15:0] d;
    set_mode(3, 2'b00);
    drive_pin(3, 1'b1, 16'hDEAD);
    drive_pin(3, 1'b0, 16'hBEEF);
    check(pol_status[3] == 1'b0, "R2 disabled channel status", pol_status[3], 0);
    read_ch(3, d);
    check(d == 16'h0, "R2 disabled channel latch", d, 0);
  endtask

  task automatic test_same_cycle();
    logic [15:0] d;
    read_ch(0, d);
    set_mode(0, 2'b11);
    drive_pin(0, 1'b1, 16'h2001);
    check(pol_status[0] == 1'b1, "R6 rising after re-arm", pol_status[0], 1);
    drive_pin(0, 1'b0, 16'h2002);
    drive_pin(0, 1'b1, 16'h2003);
    check(pol_status[0] == 1'b1, "R5 status held over captures", pol_status[0], 1);
    read_ch(0, d);
    check(d == 16'h2003, "R3 read returns last capture", d, 16'h2003);
    drive_pin(0, 1'b0, 16'h2004);
    drive_pin(0, 1'b1, 16'h2005);
    check(pol_status[0] == 1'b0, "R5 status held after falling first", pol_status[0], 0);
    // falling edge whose capture meets a read in the same cycle
    @(negedge clk);
    timer_cnt = 16'h2006;
    cap_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd_en = 1'b1;
    rd_sel = 2'd0;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data == 16'h2005, "R7 read returns pre-capture value", rd_data, 16'h2005);
    check(pol_status[0] == 1'b0, "R7 coincident capture is first", pol_status[0], 0);
    drive_pin(0, 1'b1, 16'h2007);
    check(pol_status[0] == 1'b0, "R7 next capture not first", pol_status[0], 0);
    read_ch(0, d);
    check(d == 16'h2007, "R3 read after coincident case", d, 16'h2007);
    check(pol_status[2] == 1'b0 && pol_status[1] == 1'b0, "R10 neighbours unchanged",
          pol_status, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_rising_first();
    test_falling_mode();
    test_first_only();
    test_disabled();
    test_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule